// File: doc/BRIEF.md
# Fault Snapshot Capture and Readback

This block freezes a picture of the system state at the moment a fault is seen. A capture takes the 8-bit comparator status word and the upper byte of each of four channel codes in the same clock cycle. It packs them into a two-row store of 32-bit words, modelled as flops that only commit after a programmable write latency. A capture is started by a software strobe or by a falling edge on a general-purpose input. That input counts only when the pin is configured as an input with the fault-trigger function selected. It passes through a two-flop synchronizer and a glitch filter before its edge is detected.

Software reads the store indirectly. A row-select bit chooses a row, and a read strobe copies that row into two 16-bit scratch words: the low half goes to scratch address 0x9D and the high half to 0x9E. The host writes one of those addresses into an 8-bit address register and then reads the data port.

Top module: `fault_snap`

## Requirements
- R1: After reset `busy` is 0, the store and both scratch words are zero, and `dataRd` reads 0 at every address.
- R2: A software trigger (`swFaultTrig` high at a rising edge while not busy) captures `statusIn` and `chanHiIn` as sampled at that same edge; later changes to those inputs do not alter the snapshot.
- R3: Row 1 (row select 0) holds the status byte in bits [31:24], and bits [23:0] read as zero.
- R4: Row 2 (row select 1) holds channel 0's upper code byte in bits [31:24], channel 1's in [23:16], channel 2's in [15:8] and channel 3's in [7:0]. Channel c arrives on `chanHiIn[8c+7:8c]`.
- R5: A falling edge on `gpIn` starts a capture when `gpInEn`=1, `gpOutEn`=0 and `gpFunc`=4'b0010.
- R6: A `gpIn` falling edge starts no capture when any of those three conditions is false, and a rising edge never starts one.
- R7: After an accepted trigger, `busy` is high for exactly WR_LAT sampled cycles, and the snapshot becomes readable from the store when `busy` falls.
- R8: Triggers arriving while `busy` is high are ignored: they neither change the snapshot nor lengthen `busy`.
- R9: A `readTrig` strobe copies the selected row's bits [15:0] to scratch 0x9D and bits [31:16] to scratch 0x9E. `dataRd` shows the scratch word named by the address register, which is loaded from `addrWrData` when `addrWrEn` is high.
- R10: The scratch words change only on `readTrig`, and any address other than 0x9D or 0x9E reads 0.
- R11: The `gpIn` level must stay changed for FILT_LEN consecutive synchronized cycles to count. A low pulse shorter than FILT_LEN cycles is ignored, and one of exactly FILT_LEN cycles triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statusIn | input | STATUS_W | Live comparator status word |
| chanHiIn | input | NUM_CH*8 | Live upper code byte per channel, channel c at [8c+7:8c] |
| swFaultTrig | input | 1 | Software fault strobe |
| gpIn | input | 1 | Asynchronous general-purpose input pin |
| gpInEn | input | 1 | Pin input mode enable |
| gpOutEn | input | 1 | Pin output mode enable |
| gpFunc | input | 4 | Pin input function select; 4'b0010 selects fault trigger |
| rowSel | input | 1 | Row choice for readback, 0 = row 1, 1 = row 2 |
| readTrig | input | 1 | Copy selected row into the scratch words |
| addrWrEn | input | 1 | Load the scratch address register |
| addrWrData | input | 8 | Scratch address to load |
| dataRd | output | ROW_W/2 | Scratch word at the current address |
| busy | output | 1 | Store write in progress |

## Verification
A wrong busy counter shows on `busy` within the cycle after a trigger, either as a wrong pulse length or as a pulse that restarts on a second trigger. A wrong packing lane or a broken capture shows only after a row copy and two address loads, so every sweep pattern is read back through both rows. A pin path that triggers when disarmed, or on a short glitch, raises `busy` within about five cycles of the pin change. It also shows on the next readback as an overwritten status byte.

// File: rtl/fault_snap_pkg.sv
package fault_snap_pkg;
  localparam logic [7:0] SCR_LO_ADDR   = 8'h9D;
  localparam logic [7:0] SCR_HI_ADDR   = 8'h9E;
  localparam logic [3:0] GP_FAULT_FUNC = 4'b0010;

  typedef struct packed {
    logic capture;  // sample live status and codes into the pending words
    logic commit;   // move pending words into the store
    logic copy;     // copy selected store row into scratch
  } snap_strobe_t;
endpackage

// File: rtl/fault_snap_ctrl.sv
module fault_snap_ctrl
  import fault_snap_pkg::*;
#(
  parameter int WR_LAT      = 4,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swTrig,
  input  logic         gpIn,
  input  logic         gpInEn,
  input  logic         gpOutEn,
  input  logic [3:0]   gpFunc,
  input  logic         readTrig,
  output snap_strobe_t strb,
  output logic         busy
);
  localparam int CNT_W  = $clog2(WR_LAT + 1);
  localparam int FCNT_W = $clog2(FILT_LEN + 2);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   gpSync;
  logic                   gpLvl;
  logic                   gpLvlQ;
  logic                   gpFall;
  logic                   gpArm;
  logic                   faultReq;
  logic [CNT_W-1:0]       busyCnt;

  // Pin synchronizer; reset high so no edge appears out of reset
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], gpIn};
  end
  assign gpSync = syncQ[SYNC_STAGES-1];

  generate
    if (FILT_LEN == 0) begin : g_noFilt
      always_ff @(posedge clk) begin
        if (!rstN) gpLvl <= 1'b1;
        else       gpLvl <= gpSync;
      end
    end else begin : g_filt
      logic [FCNT_W-1:0] fCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          gpLvl <= 1'b1;
          fCnt  <= '0;
        end else if (gpSync == gpLvl) begin
          fCnt  <= '0;
        end else if (fCnt == FCNT_W'(FILT_LEN - 1)) begin
          gpLvl <= gpSync;
          fCnt  <= '0;
        end else begin
          fCnt  <= fCnt + 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) gpLvlQ <= 1'b1;
    else       gpLvlQ <= gpLvl;
  end

  assign gpFall   = gpLvlQ & ~gpLvl;
  assign gpArm    = gpInEn & ~gpOutEn & (gpFunc == GP_FAULT_FUNC);
  assign faultReq = swTrig | (gpFall & gpArm);

  // Write-latency counter
  always_ff @(posedge clk) begin
    if (!rstN)                     busyCnt <= '0;
    else if (busyCnt != '0)        busyCnt <= busyCnt - 1'b1;
    else if (faultReq)             busyCnt <= CNT_W'(WR_LAT);
  end

  assign busy         = (busyCnt != '0);
  assign strb.capture = faultReq & ~busy;
  assign strb.commit  = (busyCnt == CNT_W'(1));
  assign strb.copy    = readTrig;

  // R7: a new busy window always starts at the full latency
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> busyCnt == CNT_W'(WR_LAT));

  // R2: an accepted capture opens a busy window on the next cycle
  assert_capture_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> busy);

  // R8: while busy the counter only counts down, never reloads
  assert_busy_countdown_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> busyCnt == $past(busyCnt) - 1'b1);

  // R6: without an armed falling edge or software strobe busy never rises
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(swTrig || (gpFall && gpArm)) |=> !$rose(busy));
endmodule

// File: rtl/fault_snap_dp.sv
module fault_snap_dp
  import fault_snap_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int STATUS_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  snap_strobe_t          strb,
  input  logic [STATUS_W-1:0]   statusIn,
  input  logic [NUM_CH*8-1:0]   chanHiIn,
  input  logic                  rowSel,
  input  logic                  addrWrEn,
  input  logic [7:0]            addrWrData,
  output logic [NUM_CH*4-1:0]   dataRd
);
  localparam int ROW_W  = NUM_CH * 8;
  localparam int HALF_W = ROW_W / 2;

  logic [ROW_W-1:0]  row1Now, row2Now;
  logic [ROW_W-1:0]  pend1, pend2;
  logic [ROW_W-1:0]  store1, store2;
  logic [ROW_W-1:0]  rowPick;
  logic [HALF_W-1:0] scrLo, scrHi;
  logic [7:0]        addrQ;

  // Packing: status at the top of row 1, channel 0 at the top of row 2
  assign row1Now = {statusIn, {(ROW_W - STATUS_W){1'b0}}};
  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pack
      assign row2Now[ROW_W-1-8*ch -: 8] = chanHiIn[8*ch +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend1  <= '0;
      pend2  <= '0;
      store1 <= '0;
      store2 <= '0;
    end else begin
      if (strb.capture) begin
        pend1 <= row1Now;
        pend2 <= row2Now;
      end
      if (strb.commit) begin
        store1 <= pend1;
        store2 <= pend2;
      end
    end
  end

  assign rowPick = rowSel ? store2 : store1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrLo <= '0;
      scrHi <= '0;
      addrQ <= '0;
    end else begin
      if (strb.copy) begin
        scrLo <= rowPick[HALF_W-1:0];
        scrHi <= rowPick[ROW_W-1:HALF_W];
      end
      if (addrWrEn) addrQ <= addrWrData;
    end
  end

  always_comb begin
    if (addrQ == SCR_LO_ADDR)      dataRd = scrLo;
    else if (addrQ == SCR_HI_ADDR) dataRd = scrHi;
    else                           dataRd = '0;
  end

  // R10: scratch holds its value unless a copy strobe occurs
  assert_scratch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.copy |=> ($stable(scrLo) && $stable(scrHi)));

  // R7: the store changes only at the end of a write window
  assert_store_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(store1) && $stable(store2)));
endmodule

// File: rtl/fault_snap.sv
module fault_snap
  import fault_snap_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int STATUS_W    = 8,
  parameter int WR_LAT      = 4,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [STATUS_W-1:0]   statusIn,
  input  logic [NUM_CH*8-1:0]   chanHiIn,
  input  logic                  swFaultTrig,
  input  logic                  gpIn,
  input  logic                  gpInEn,
  input  logic                  gpOutEn,
  input  logic [3:0]            gpFunc,
  input  logic                  rowSel,
  input  logic                  readTrig,
  input  logic                  addrWrEn,
  input  logic [7:0]            addrWrData,
  output logic [NUM_CH*4-1:0]   dataRd,
  output logic                  busy
);
  snap_strobe_t strb;

  fault_snap_ctrl #(
    .WR_LAT(WR_LAT), .FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .swTrig(swFaultTrig), .gpIn(gpIn),
    .gpInEn(gpInEn), .gpOutEn(gpOutEn), .gpFunc(gpFunc),
    .readTrig(readTrig), .strb(strb), .busy(busy)
  );

  fault_snap_dp #(
    .NUM_CH(NUM_CH), .STATUS_W(STATUS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .statusIn(statusIn),
    .chanHiIn(chanHiIn), .rowSel(rowSel), .addrWrEn(addrWrEn),
    .addrWrData(addrWrData), .dataRd(dataRd)
  );
endmodule

// File: tb/fault_snap_bench.sv
module fault_snap_bench;
  localparam int WR_LAT   = 4;
  localparam int FILT_LEN = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  statusIn;
  logic [31:0] chanHiIn;
  logic        swFaultTrig, gpIn, gpInEn, gpOutEn, rowSel, readTrig, addrWrEn;
  logic [3:0]  gpFunc;
  logic [7:0]  addrWrData;
  logic [15:0] dataRd;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fault_snap #(.WR_LAT(WR_LAT), .FILT_LEN(FILT_LEN)) u_fault_snap (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .chanHiIn(chanHiIn),
    .swFaultTrig(swFaultTrig), .gpIn(gpIn), .gpInEn(gpInEn), .gpOutEn(gpOutEn),
    .gpFunc(gpFunc), .rowSel(rowSel), .readTrig(readTrig), .addrWrEn(addrWrEn),
    .addrWrData(addrWrData), .dataRd(dataRd), .busy(busy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic readAddr(input logic [7:0] a, output logic [15:0] v);
    addrWrData = a; addrWrEn = 1'b1; tick(); addrWrEn = 1'b0;
    v = dataRd;
  endtask

  task automatic readRow(input logic r, output logic [31:0] w);
    logic [15:0] lo, hi;
    rowSel = r; readTrig = 1'b1; tick(); readTrig = 1'b0;
    readAddr(8'h9D, lo);
    readAddr(8'h9E, hi);
    w = {hi, lo};
  endtask

  // Wait n cycles, returning how many samples showed busy
  task automatic waitCount(input int n, output int nb);
    nb = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (busy) nb++;
    end
  endtask

  function automatic logic [31:0] packRow2(input logic [31:0] hiBytes);
    logic [31:0] r;
    for (int c = 0; c < 4; c++) r[31-8*c -: 8] = hiBytes[8*c +: 8];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] w, expStat, expRow2;
    logic [15:0] v;
    logic [7:0]  lastStat;
    int nb;

    rstN = 1'b0; statusIn = '0; chanHiIn = '0; swFaultTrig = 0; gpIn = 1;
    gpInEn = 0; gpOutEn = 0; gpFunc = 0; rowSel = 0; readTrig = 0;
    addrWrEn = 0; addrWrData = 0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1: reset state
    chk("R1 busy", {31'b0, busy}, 0);
    readAddr(8'h9D, v); chk("R1 scr lo", {16'b0, v}, 0);
    readAddr(8'h9E, v); chk("R1 scr hi", {16'b0, v}, 0);
    readRow(1'b0, w); chk("R1 row1", w, 0);
    readRow(1'b1, w); chk("R1 row2", w, 0);

    // R2 R3 R4 R9: software captures over a sweep of patterns
    for (int i = 0; i < 8; i++) begin
      logic [7:0]  st;
      logic [31:0] hb;
      st = 8'((i * 37 + 5) & 255);
      for (int c = 0; c < 4; c++) hb[8*c +: 8] = 8'(((i * 4099 + c * 1237 + 291) >> 8) & 255);
      statusIn = st; chanHiIn = hb;
      swFaultTrig = 1; tick(); swFaultTrig = 0;
      statusIn = ~st; chanHiIn = ~hb;  // R2: later changes must not leak in
      waitCount(WR_LAT + 2, nb);
      readRow(1'b0, w); chk("R3 R2 row1 status/low zero", w, {st, 24'h0});
      readRow(1'b1, w); chk("R4 R2 row2 packing", w, packRow2(hb));
      lastStat = st;
    end

    // R10: scratch changes only on copy; other addresses read zero
    expRow2 = w;
    statusIn = 8'hA5; chanHiIn = 32'h11223344;
    swFaultTrig = 1; tick(); swFaultTrig = 0;
    waitCount(WR_LAT + 2, nb);
    readAddr(8'h9D, v); chk("R10 scratch lo held", {16'b0, v}, {16'b0, expRow2[15:0]});
    readAddr(8'h9E, v); chk("R10 scratch hi held", {16'b0, v}, {16'b0, expRow2[31:16]});
    readAddr(8'h00, v); chk("R10 addr 00", {16'b0, v}, 0);
    readAddr(8'h9C, v); chk("R10 addr 9C", {16'b0, v}, 0);
    readAddr(8'h9F, v); chk("R10 addr 9F", {16'b0, v}, 0);
    readAddr(8'hFF, v); chk("R10 addr FF", {16'b0, v}, 0);
    readRow(1'b1, w); chk("R9 row2 after copy", w, packRow2(32'h11223344));
    lastStat = 8'hA5;

    // R7 R8: busy length and retrigger while busy
    statusIn = 8'h3C;
    swFaultTrig = 1; tick(); swFaultTrig = 0;
    nb = busy ? 1 : 0;
    statusIn = 8'hC3; swFaultTrig = 1; tick(); swFaultTrig = 0;
    if (busy) nb++;
    begin
      int more;
      waitCount(2 * WR_LAT, more);
      nb += more;
    end
    chk("R7 R8 busy length", nb, WR_LAT);
    readRow(1'b0, w); chk("R8 retrigger ignored", w, {8'h3C, 24'h0});
    lastStat = 8'h3C;

    // R6: disarmed pin configurations ignore a falling edge
    for (int k = 0; k < 3; k++) begin
      gpInEn  = (k != 0);
      gpOutEn = (k == 1);
      gpFunc  = (k == 2) ? 4'b0011 : 4'b0010;
      statusIn = 8'(8'h50 + k);
      gpIn = 0; waitCount(20, nb);
      chk("R6 disarmed fall no busy", nb, 0);
      gpIn = 1; waitCount(20, nb);
      readRow(1'b0, w); chk("R6 disarmed row1 kept", w, {lastStat, 24'h0});
    end

    // R6: rising edge while armed does not trigger
    gpInEn = 0; gpOutEn = 0; gpFunc = 4'b0010;
    gpIn = 0; waitCount(20, nb);
    gpInEn = 1; statusIn = 8'h77;
    waitCount(10, nb);
    gpIn = 1; waitCount(20, nb);
    chk("R6 rising edge no busy", nb, 0);

    // R11: short low pulses are filtered, a pulse of FILT_LEN passes
    for (int wdt = 1; wdt < FILT_LEN; wdt++) begin
      statusIn = 8'(8'h60 + wdt);
      gpIn = 0; repeat (wdt) tick(); gpIn = 1;
      waitCount(20, nb);
      chk("R11 glitch ignored", nb, 0);
    end
    readRow(1'b0, w); chk("R11 row1 after glitches", w, {lastStat, 24'h0});

    // R5 R11: armed falling edge held exactly FILT_LEN cycles captures
    statusIn = 8'h9A; chanHiIn = 32'hDEADBEEF;
    gpIn = 0; repeat (FILT_LEN) tick(); gpIn = 1;
    waitCount(20, nb);
    chk("R5 R11 armed fall busy", nb, WR_LAT);
    readRow(1'b0, w); chk("R5 pin capture row1", w, {8'h9A, 24'h0});
    readRow(1'b1, w); chk("R5 pin capture row2", w, packRow2(32'hDEADBEEF));

    // R5: long held low level triggers once
    statusIn = 8'h0F;
    gpIn = 0; waitCount(30, nb);
    chk("R5 long low busy once", nb, WR_LAT);
    gpIn = 1; waitCount(20, nb);
    readRow(1'b0, w); chk("R5 long low row1", w, {8'h0F, 24'h0});

    done = 1;
    summary();
  end
endmodule